// File: doc/BRIEF.md
# Level-1 Physics Trigger Decision Unit

This unit makes the first-level accept-or-cut call for each detector sample. On every clock it takes four summaries from the upstream summing chain: forward-calorimeter energy, barrel-calorimeter energy, the track count from the forward time-of-flight wall and the track count from the start counter. A new sample can arrive on every clock, so the unit keeps pace with the digitiser pipelines. It has no stall and no handshake.

Two physics tests run side by side on each sample. The first is a Boolean low-energy veto with two terms. The second is a weighted linear discriminant that includes an energy-ratio term; it is evaluated without a divider by multiplying both sides through by the barrel energy plus one. A mode input chooses which test forms the cut flag. Per-subsystem acceptance windows can also reject a sample on their own.

An accepted sample raises the trigger output a fixed two cycles after capture, plus a programmable delay. The sample's timestamp travels with it. All thresholds and coefficients are quasi-static inputs held by a register bank outside this block.

Top module: `l1_trig_decide`

## Requirements
- R1: The veto cuts a valid sample when forward energy is strictly below `cfg_fwd_thr` and the time-of-flight track count is zero.
- R2: The veto also cuts when forward plus barrel energy is strictly below `cfg_tot_thr` and forward energy is strictly below barrel energy. A sample that meets neither R1 nor R2 passes the veto.
- R3: The discriminant cuts when `cfg_z` < `cfg_kt`·Ntof + `cfg_ke`·Efwd + `cfg_kr`·(Efwd+1)/(Ebar+1), computed exactly with no rounding of the ratio. Equality accepts. All four coefficients share one unsigned binary scale.
- R4: `cfg_mode` selects the cut flag: 0 = veto only, 1 = discriminant only, 2 = cut only when both the veto and the discriminant cut, 3 = neither (only the windows can cut).
- R5: Each track-count window has a 2-bit code: 0 off, 1 cut if count < limit, 2 cut if count > limit, 3 cut if count ≠ limit. A window failure cuts the sample in every mode.
- R6: Each energy window has a 2-bit code: 0 or 3 off, 1 cut if energy < limit, 2 cut if energy > limit. A window failure cuts the sample in every mode.
- R7: For an accepted valid sample presented before clock edge k, `trig` is high with `trig_ts` equal to that sample's timestamp for exactly the cycle after edge k+1+D. Here D is `cfg_dly` clamped to MAXD (16 by default).
- R8: A sample with `in_vld` low never produces a trigger, whatever its data.
- R9: Synchronous `rst` holds `trig` low and discards every sample still in flight.
- R10: Samples on consecutive clocks are each judged independently and leave in the same order on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | Cut selection (R4) |
| cfg_fwd_thr | input | EW | Forward-energy veto threshold |
| cfg_tot_thr | input | EW+1 | Total-energy veto threshold |
| cfg_z | input | KW | Discriminant limit Z |
| cfg_kt | input | KW | Weight on time-of-flight track count |
| cfg_ke | input | KW | Weight on forward energy |
| cfg_kr | input | KW | Weight on energy ratio |
| cfg_tof_wm | input | 2 | Time-of-flight window code |
| cfg_tof_wt | input | CW | Time-of-flight window limit |
| cfg_sc_wm | input | 2 | Start-counter window code |
| cfg_sc_wt | input | CW | Start-counter window limit |
| cfg_fwd_wm | input | 2 | Forward-energy window code |
| cfg_fwd_wt | input | EW | Forward-energy window limit |
| cfg_bar_wm | input | 2 | Barrel-energy window code |
| cfg_bar_wt | input | EW | Barrel-energy window limit |
| cfg_dly | input | DLW | Output delay in cycles |
| in_vld | input | 1 | Sample valid |
| in_efwd | input | EW | Forward-calorimeter energy |
| in_ebar | input | EW | Barrel-calorimeter energy |
| in_ntof | input | CW | Forward time-of-flight track count |
| in_nsc | input | CW | Start-counter track count |
| in_ts | input | TW | Sample timestamp |
| trig | output | 1 | Accept pulse |
| trig_ts | output | TW | Timestamp of the accepted sample |

## Verification
A window failure and a discriminant accept can fall on the same sample. The bench sets the time-of-flight window to a minimum of three and sends two tracks with energies that the discriminant alone accepts in mode 1. The window must win, so no trigger appears at the expected output cycle. The veto and the discriminant can also both flag one sample. Mode 2 is driven with samples where only the veto cuts, only the discriminant cuts, and both cut, and a trigger is expected only when one of the two tests passes the sample.

// File: rtl/l1_trig_decide.sv
module l1_trig_decide #(
  parameter int EW = 12,
  parameter int CW = 6,
  parameter int KW = 12,
  parameter int TW = 16,
  parameter int MAXD = 16,
  localparam int DLW = $clog2(MAXD + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     cfg_mode,
  input  logic [EW-1:0]  cfg_fwd_thr,
  input  logic [EW:0]    cfg_tot_thr,
  input  logic [KW-1:0]  cfg_z,
  input  logic [KW-1:0]  cfg_kt,
  input  logic [KW-1:0]  cfg_ke,
  input  logic [KW-1:0]  cfg_kr,
  input  logic [1:0]     cfg_tof_wm,
  input  logic [CW-1:0]  cfg_tof_wt,
  input  logic [1:0]     cfg_sc_wm,
  input  logic [CW-1:0]  cfg_sc_wt,
  input  logic [1:0]     cfg_fwd_wm,
  input  logic [EW-1:0]  cfg_fwd_wt,
  input  logic [1:0]     cfg_bar_wm,
  input  logic [EW-1:0]  cfg_bar_wt,
  input  logic [DLW-1:0] cfg_dly,
  input  logic           in_vld,
  input  logic [EW-1:0]  in_efwd,
  input  logic [EW-1:0]  in_ebar,
  input  logic [CW-1:0]  in_ntof,
  input  logic [CW-1:0]  in_nsc,
  input  logic [TW-1:0]  in_ts,
  output logic           trig,
  output logic [TW-1:0]  trig_ts
);
  localparam int LW1 = KW + EW + 1;
  localparam int LW2 = KW + 2 * EW + 2;
  localparam int AW  = (MAXD > 1) ? $clog2(MAXD) : 1;

  function automatic logic win_bad(input logic [1:0] m, input logic [EW-1:0] x,
                                   input logic [EW-1:0] t, input logic has_exact);
    case (m)
      2'd1:    return x < t;
      2'd2:    return x > t;
      2'd3:    return has_exact && (x != t);
      default: return 1'b0;
    endcase
  endfunction

  // stage 1: veto terms, windows, linear part of the discriminant
  logic [EW:0]    tot;
  logic           cut_a, cut_b, wf;
  logic [LW1-1:0] lin;

  assign tot   = {1'b0, in_efwd} + {1'b0, in_ebar};
  assign cut_a = (in_efwd < cfg_fwd_thr) && (in_ntof == '0);
  assign cut_b = (tot < cfg_tot_thr) && (in_efwd < in_ebar);
  assign wf    = win_bad(cfg_tof_wm, EW'(in_ntof), EW'(cfg_tof_wt), 1'b1)
               | win_bad(cfg_sc_wm,  EW'(in_nsc),  EW'(cfg_sc_wt),  1'b1)
               | win_bad(cfg_fwd_wm, in_efwd,      cfg_fwd_wt,      1'b0)
               | win_bad(cfg_bar_wm, in_ebar,      cfg_bar_wt,      1'b0);
  assign lin   = LW1'(cfg_kt) * LW1'(in_ntof) + LW1'(cfg_ke) * LW1'(in_efwd);

  logic           s1_vld, s1_cc, s1_wf;
  logic [TW-1:0]  s1_ts;
  logic [EW-1:0]  s1_ef, s1_eb;
  logic [LW1-1:0] s1_lin;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
    end else begin
      s1_vld <= in_vld;
      s1_ts  <= in_ts;
      s1_ef  <= in_efwd;
      s1_eb  <= in_ebar;
      s1_lin <= lin;
      s1_cc  <= cut_a | cut_b;
      s1_wf  <= wf;
    end
  end

  // stage 2: ratio term multiplied through by (Ebar+1), mode select
  logic [LW2-1:0] eb1, ef1, lhs, rhs;
  logic           dc, sel;

  assign eb1 = LW2'(s1_eb) + LW2'(1);
  assign ef1 = LW2'(s1_ef) + LW2'(1);
  assign lhs = LW2'(cfg_z) * eb1;
  assign rhs = LW2'(s1_lin) * eb1 + LW2'(cfg_kr) * ef1;
  assign dc  = lhs < rhs;

  always_comb begin
    case (cfg_mode)
      2'd0:    sel = s1_cc;
      2'd1:    sel = dc;
      2'd2:    sel = s1_cc & dc;
      default: sel = 1'b0;
    endcase
  end

  logic          s2_acc;
  logic [TW-1:0] s2_ts;

  always_ff @(posedge clk) begin
    if (rst) s2_acc <= 1'b0;
    else begin
      s2_acc <= s1_vld & ~(s1_wf | sel);
      s2_ts  <= s1_ts;
    end
  end

  // programmable delay line
  logic [MAXD-1:0] dl_acc;
  logic [TW-1:0]   dl_ts [MAXD];

  always_ff @(posedge clk) begin
    if (rst) dl_acc <= '0;
    else     dl_acc <= {dl_acc[MAXD-2:0], s2_acc};
  end

  always_ff @(posedge clk) dl_ts[0] <= s2_ts;

  for (genvar i = 1; i < MAXD; i++) begin : g_dly
    always_ff @(posedge clk) dl_ts[i] <= dl_ts[i-1];
  end

  logic [DLW-1:0] dsel;
  logic [AW-1:0]  tap;

  assign dsel = (cfg_dly > DLW'(MAXD)) ? DLW'(MAXD) : cfg_dly;
  assign tap  = AW'(dsel - DLW'(1));

  always_comb begin
    if (dsel == '0) begin
      trig    = s2_acc;
      trig_ts = s2_ts;
    end else begin
      trig    = dl_acc[tap];
      trig_ts = dl_ts[tap];
    end
  end

  // R1, R2: veto alone decides in mode 0 when the windows pass
  p_veto_cut_r1: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && !s1_wf && s1_cc && cfg_mode == 2'd0) |=> !s2_acc);
  p_veto_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && !s1_wf && !s1_cc && cfg_mode == 2'd0) |=> s2_acc);
  p_disc_r3: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && !s1_wf && cfg_mode == 2'd1) |=> (s2_acc == !$past(dc)));
  p_bypass_r4: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && !s1_wf && cfg_mode == 2'd3) |=> s2_acc);
  // R5 and R6: a failed window vetoes in any mode
  p_win_veto_r5: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_wf) |=> !s2_acc);
  p_need_vld_r8: assert property (@(posedge clk) disable iff (rst)
    s2_acc |-> $past(s1_vld));
endmodule

// File: tb/sim_l1_trig_decide.sv
`timescale 1ns/1ps
module sim_l1_trig_decide;
  logic clk = 1'b0, rst = 1'b1;
  logic [1:0]  cfg_mode, cfg_tof_wm, cfg_sc_wm, cfg_fwd_wm, cfg_bar_wm;
  logic [11:0] cfg_fwd_thr, cfg_z, cfg_kt, cfg_ke, cfg_kr, cfg_fwd_wt, cfg_bar_wt;
  logic [12:0] cfg_tot_thr;
  logic [5:0]  cfg_tof_wt, cfg_sc_wt;
  logic [4:0]  cfg_dly;
  logic        in_vld;
  logic [11:0] in_efwd, in_ebar;
  logic [5:0]  in_ntof, in_nsc;
  logic [15:0] in_ts;
  logic        trig;
  logic [15:0] trig_ts;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  l1_trig_decide u0 (.*);

  typedef struct packed {
    logic [11:0] ef; logic [11:0] eb; logic [5:0] nt; logic [1:0] md; logic ex;
  } vec_t;

  // Z=500 kt=10 ke=2 kr=100, veto thresholds 50/50, windows off, D=0
  localparam vec_t TAB [13] = '{
    '{12'd40,  12'd10, 6'd0,  2'd0, 1'b0},  // R1 forward low, no tracks
    '{12'd40,  12'd10, 6'd1,  2'd0, 1'b1},  // R1 one track rescues
    '{12'd20,  12'd25, 6'd2,  2'd0, 1'b0},  // R2 total low, fwd<bar
    '{12'd20,  12'd20, 6'd2,  2'd0, 1'b1},  // R2 fwd==bar passes
    '{12'd100, 12'd99, 6'd5,  2'd1, 1'b1},  // R3 well inside
    '{12'd300, 12'd0,  6'd0,  2'd1, 1'b0},  // R3 large ratio
    '{12'd0,   12'd0,  6'd40, 2'd1, 1'b1},  // R3 exact equality accepts
    '{12'd0,   12'd0,  6'd41, 2'd1, 1'b0},  // R3 one step over
    '{12'd3,   12'd8,  6'd45, 2'd1, 1'b0},  // R3 fraction 0.44 must count
    '{12'd40,  12'd10, 6'd0,  2'd2, 1'b1},  // R4 veto only cuts
    '{12'd300, 12'd0,  6'd0,  2'd2, 1'b1},  // R4 discriminant only cuts
    '{12'd40,  12'd0,  6'd0,  2'd2, 1'b0},  // R4 both cut
    '{12'd40,  12'd0,  6'd0,  2'd3, 1'b1}   // R4 no test selected
  };
  localparam string TAG [13] = '{"R1","R1","R2","R2","R3","R3","R3","R3","R3",
                                 "R4","R4","R4","R4"};

  task automatic chk(input string tag, input logic et, input logic [15:0] ets);
    checks++;
    if (trig !== et || (et && trig_ts !== ets)) begin
      errs++;
      $display("FAIL %s: trig=%0b ts=%0d expected trig=%0b ts=%0d", tag, trig, trig_ts, et, ets);
    end
  endtask

  task automatic defaults();
    cfg_mode = 2'd0; cfg_fwd_thr = 12'd50; cfg_tot_thr = 13'd50;
    cfg_z = 12'd500; cfg_kt = 12'd10; cfg_ke = 12'd2; cfg_kr = 12'd100;
    cfg_tof_wm = 2'd0; cfg_sc_wm = 2'd0; cfg_fwd_wm = 2'd0; cfg_bar_wm = 2'd0;
    cfg_tof_wt = '0; cfg_sc_wt = '0; cfg_fwd_wt = '0; cfg_bar_wt = '0; cfg_dly = 5'd0;
  endtask

  task automatic put(input logic [11:0] ef, eb, input logic [5:0] nt, ns, input logic [15:0] ts);
    @(negedge clk);
    in_vld = 1'b1; in_efwd = ef; in_ebar = eb; in_ntof = nt; in_nsc = ns; in_ts = ts;
  endtask

  // one sample, then wait until the output cycle for delay d
  task automatic one(input logic [11:0] ef, eb, input logic [5:0] nt, ns,
                     input logic [15:0] ts, input int d);
    put(ef, eb, nt, ns, ts);
    @(negedge clk) in_vld = 1'b0;
    repeat (1 + d) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: run did not end, expected end");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    defaults();
    in_vld = 1'b1; in_efwd = 12'd500; in_ebar = 12'd0; in_ntof = 6'd3; in_nsc = 6'd0; in_ts = 16'd7;
    cfg_mode = 2'd3;
    // R9: accepting samples during reset never trigger
    repeat (4) @(negedge clk);
    chk("R9 in reset", 1'b0, 16'd0);
    in_vld = 1'b0;
    @(negedge clk) rst = 1'b0;
    chk("R9 after release", 1'b0, 16'd0);
    defaults();

    foreach (TAB[i]) begin
      cfg_mode = TAB[i].md;
      one(TAB[i].ef, TAB[i].eb, TAB[i].nt, 6'd0, 16'(100 + i), 0);
      chk(TAG[i], TAB[i].ex, 16'(100 + i));
    end

    // R5: track windows (mode 3 so only windows act)
    cfg_mode = 2'd3; cfg_tof_wm = 2'd1; cfg_tof_wt = 6'd3;
    one(12'd200, 12'd0, 6'd2, 6'd0, 16'd201, 0); chk("R5 tof min fail", 1'b0, 16'd201);
    one(12'd200, 12'd0, 6'd3, 6'd0, 16'd202, 0); chk("R5 tof min edge", 1'b1, 16'd202);
    // R5 concurrent: discriminant accepts, window fails
    cfg_mode = 2'd1;
    one(12'd100, 12'd99, 6'd2, 6'd0, 16'd203, 0); chk("R5 window beats discriminant", 1'b0, 16'd203);
    one(12'd100, 12'd99, 6'd3, 6'd0, 16'd204, 0); chk("R5 window ok discriminant ok", 1'b1, 16'd204);
    cfg_mode = 2'd3; cfg_tof_wm = 2'd0;
    cfg_sc_wm = 2'd2; cfg_sc_wt = 6'd5;
    one(12'd200, 12'd0, 6'd0, 6'd6, 16'd205, 0); chk("R5 sc max fail", 1'b0, 16'd205);
    one(12'd200, 12'd0, 6'd0, 6'd5, 16'd206, 0); chk("R5 sc max edge", 1'b1, 16'd206);
    cfg_sc_wm = 2'd3; cfg_sc_wt = 6'd4;
    one(12'd200, 12'd0, 6'd0, 6'd4, 16'd207, 0); chk("R5 sc exact hit", 1'b1, 16'd207);
    one(12'd200, 12'd0, 6'd0, 6'd5, 16'd208, 0); chk("R5 sc exact miss", 1'b0, 16'd208);
    cfg_sc_wm = 2'd0;

    // R6: energy windows
    cfg_fwd_wm = 2'd2; cfg_fwd_wt = 12'd100;
    one(12'd101, 12'd0, 6'd0, 6'd0, 16'd301, 0); chk("R6 fwd max fail", 1'b0, 16'd301);
    one(12'd100, 12'd0, 6'd0, 6'd0, 16'd302, 0); chk("R6 fwd max edge", 1'b1, 16'd302);
    cfg_fwd_wm = 2'd0; cfg_bar_wm = 2'd1; cfg_bar_wt = 12'd10;
    one(12'd100, 12'd9,  6'd0, 6'd0, 16'd303, 0); chk("R6 bar min fail", 1'b0, 16'd303);
    one(12'd100, 12'd10, 6'd0, 6'd0, 16'd304, 0); chk("R6 bar min edge", 1'b1, 16'd304);
    cfg_bar_wm = 2'd3;
    one(12'd100, 12'd0,  6'd0, 6'd0, 16'd305, 0); chk("R6 code 3 is off", 1'b1, 16'd305);
    cfg_bar_wm = 2'd0;

    // R7: latency 2+D exactly
    cfg_dly = 5'd5;
    one(12'd100, 12'd0, 6'd0, 6'd0, 16'd401, 4); chk("R7 one cycle early", 1'b0, 16'd0);
    @(negedge clk); chk("R7 delay 5", 1'b1, 16'd401);
    @(negedge clk); chk("R7 single cycle pulse", 1'b0, 16'd0);
    cfg_dly = 5'd31;
    one(12'd100, 12'd0, 6'd0, 6'd0, 16'd402, 15); chk("R7 clamp early", 1'b0, 16'd0);
    @(negedge clk); chk("R7 clamped to 16", 1'b1, 16'd402);

    // R10: back-to-back samples with D=3
    cfg_dly = 5'd3;
    put(12'd100, 12'd0, 6'd0, 6'd0, 16'd501);
    put(12'd100, 12'd0, 6'd0, 6'd0, 16'd502); cfg_mode = 2'd3;
    @(negedge clk);
    in_vld = 1'b1; in_efwd = 12'd100; in_ebar = 12'd0; in_ntof = 6'd0; in_nsc = 6'd9; in_ts = 16'd503;
    cfg_sc_wm = 2'd2; cfg_sc_wt = 6'd5;
    put(12'd100, 12'd0, 6'd0, 6'd0, 16'd504);
    @(negedge clk) in_vld = 1'b0;
    @(negedge clk); chk("R10 first", 1'b1, 16'd501);
    @(negedge clk); chk("R10 second", 1'b1, 16'd502);
    @(negedge clk); chk("R10 third cut", 1'b0, 16'd0);
    @(negedge clk); chk("R10 fourth", 1'b1, 16'd504);
    cfg_sc_wm = 2'd0;

    // R8: invalid samples never trigger
    cfg_dly = 5'd0;
    @(negedge clk);
    in_vld = 1'b0; in_efwd = 12'd100; in_ts = 16'd601;
    repeat (3) @(negedge clk);
    chk("R8 invalid ignored", 1'b0, 16'd0);

    // R9: reset drops in-flight samples
    cfg_dly = 5'd4;
    put(12'd100, 12'd0, 6'd0, 6'd0, 16'd701);
    @(negedge clk) begin in_vld = 1'b0; rst = 1'b1; end
    repeat (2) @(negedge clk);
    rst = 1'b0;
    begin
      logic seen = 1'b0;
      for (int k = 0; k < 8; k++) begin @(negedge clk); seen |= trig; end
      checks++;
      if (seen !== 1'b0) begin
        errs++; $display("FAIL R9 flush: trig=%0b expected trig=0", seen);
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule